// File: doc/BRIEF.md
# RTC Periodic Interrupt Generator

This block drives an active-low interrupt line toward a host CPU from the state of a real-time clock. A 3-bit select input picks one of eight behaviours. The line can be held inactive or held active. It can follow one of two square-wave phase signals from the clock prescaler. Or it can run in a latched level mode, where a calendar event pulls the line low until software clears it.

In level mode, a one-cycle second-increment tick qualifies each event. The current seconds, minutes, hours and day-of-month values are compared while the tick is high, and these values must already hold the updated time in that cycle. A matching event sets an internal pending flag on the next clock edge. The line stays low until a clear strobe arrives, which is the register write of zero to the flag. The prescaler and the time counters sit outside this block.

Top module: `rtc_pint_gen`

## Requirements
- R1: Select 000 keeps irq_no at 1 regardless of every other input.
- R2: Select 001 holds irq_no at 0 continuously.
- R3: Select 010 makes irq_no equal to ph2_i (2 Hz phase), and select 011 makes irq_no equal to ph1_i (1 Hz phase), with no clock delay; the prescaler starts each phase low at the second increment.
- R4: Select 100 raises an event on every cycle in which sec_tick_i is 1.
- R5: Select 101 raises an event only when sec_tick_i is 1 and sec_i is 0.
- R6: Select 110 raises an event only when sec_tick_i is 1 and both sec_i and min_i are 0.
- R7: Select 111 raises an event only when sec_tick_i is 1, sec_i, min_i and hour_i are 0, and mday_i is 1.
- R8: In level modes (select bit 2 set), an event sets the pending flag at the next clock edge, and irq_no is 0 exactly while the flag is set. A flag_clr_i pulse without an event clears the flag at the next edge.
- R9: An event in the same cycle as flag_clr_i, or an event while the flag is already set, leaves the flag set.
- R10: Any change of sel_i clears the flag at the next edge, and an event in the cycle of the change is discarded. The flag is also held clear in the non-level modes, so no level-mode state survives a mode change.
- R11: Asserting rst_ni low clears the flag at once, without waiting for a clock, so irq_no is 1 in level mode during reset.
- R12: In level modes, ph2_i and ph1_i have no effect on irq_no.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sel_i | input | 3 | Interrupt mode select |
| ph2_i | input | 1 | 2 Hz 50% phase from prescaler |
| ph1_i | input | 1 | 1 Hz 50% phase from prescaler |
| sec_tick_i | input | 1 | One-cycle pulse on seconds increment |
| sec_i | input | SEC_W | Current seconds |
| min_i | input | MIN_W | Current minutes |
| hour_i | input | HOUR_W | Current hours |
| mday_i | input | DAY_W | Current day of month (starts at 1) |
| flag_clr_i | input | 1 | Write strobe clearing the pending flag |
| irq_no | output | 1 | Active-low interrupt |

## Verification
Assertions check the flag's state transitions on every cycle: an accepted event sets it, it holds while no clear arrives, a clear alone drops it, and a select change wipes it. They also check that the flag never rises without an event one cycle earlier. The bench scenarios are the only place the calendar-match conditions of each select code are shown, along with the zero-delay following of the phase inputs, the priority of an event over a simultaneous clear, and the asynchronous effect of reset on the output.

// File: rtl/rtc_pint_pkg.sv
package rtc_pint_pkg;
  typedef enum logic [2:0] {
    PI_OFF   = 3'b000,
    PI_LOW   = 3'b001,
    PI_P2HZ  = 3'b010,
    PI_P1HZ  = 3'b011,
    PI_L_SEC = 3'b100,
    PI_L_MIN = 3'b101,
    PI_L_HR  = 3'b110,
    PI_L_MON = 3'b111
  } pint_sel_e;

  localparam int unsigned SEL_W = 3;
endpackage

// File: rtl/pint_event_det.sv
module pint_event_det #(
  parameter int unsigned SEC_W  = 6,
  parameter int unsigned MIN_W  = 6,
  parameter int unsigned HOUR_W = 5,
  parameter int unsigned DAY_W  = 5
) (
  input  logic [1:0]        kind_i,
  input  logic              tick_i,
  input  logic [SEC_W-1:0]  sec_i,
  input  logic [MIN_W-1:0]  min_i,
  input  logic [HOUR_W-1:0] hour_i,
  input  logic [DAY_W-1:0]  mday_i,
  output logic              evt_o
);
  localparam logic [DAY_W-1:0] FIRST_DAY = DAY_W'(1);

  logic sec_z, min_z, hour_z, day_one;
  logic [3:0] match;

  assign sec_z   = (sec_i == '0);
  assign min_z   = (min_i == '0);
  assign hour_z  = (hour_i == '0);
  assign day_one = (mday_i == FIRST_DAY);

  // index = low two select bits
  assign match[0] = 1'b1;
  assign match[1] = sec_z;
  assign match[2] = sec_z & min_z;
  assign match[3] = sec_z & min_z & hour_z & day_one;

  assign evt_o = tick_i & match[kind_i];
endmodule

// File: rtl/pint_flag.sv
module pint_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic level_i,
  input  logic sel_chg_i,
  input  logic evt_i,
  input  logic clr_i,
  output logic flag_o
);
  logic flag_d;

  always_comb begin
    flag_d = flag_o;
    if (!level_i || sel_chg_i) flag_d = 1'b0;
    else if (evt_i)            flag_d = 1'b1;  // event beats clear
    else if (clr_i)            flag_d = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flag_o <= 1'b0;
    else         flag_o <= flag_d;
  end

  assert_evt_sets_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    level_i && !sel_chg_i && evt_i |=> flag_o);

  assert_flag_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_o && level_i && !sel_chg_i && !clr_i |=> flag_o);

  assert_clr_drops_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    level_i && !sel_chg_i && clr_i && !evt_i |=> !flag_o);

  assert_chg_clears_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_chg_i || !level_i |=> !flag_o);

  assert_rise_needs_evt_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flag_o) |-> $past(evt_i));
endmodule

// File: rtl/rtc_pint_gen.sv
module rtc_pint_gen
  import rtc_pint_pkg::*;
#(
  parameter int unsigned SEC_W  = 6,
  parameter int unsigned MIN_W  = 6,
  parameter int unsigned HOUR_W = 5,
  parameter int unsigned DAY_W  = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [SEL_W-1:0]  sel_i,
  input  logic              ph2_i,
  input  logic              ph1_i,
  input  logic              sec_tick_i,
  input  logic [SEC_W-1:0]  sec_i,
  input  logic [MIN_W-1:0]  min_i,
  input  logic [HOUR_W-1:0] hour_i,
  input  logic [DAY_W-1:0]  mday_i,
  input  logic              flag_clr_i,
  output logic              irq_no
);
  logic [SEL_W-1:0] sel_q;
  logic             sel_chg, level, evt, flag;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sel_q <= PI_OFF;
    else         sel_q <= sel_i;
  end

  assign sel_chg = (sel_q != sel_i);
  assign level   = sel_i[SEL_W-1];

  pint_event_det #(
    .SEC_W(SEC_W), .MIN_W(MIN_W), .HOUR_W(HOUR_W), .DAY_W(DAY_W)
  ) u_det (
    .kind_i (sel_i[1:0]),
    .tick_i (sec_tick_i),
    .sec_i  (sec_i),
    .min_i  (min_i),
    .hour_i (hour_i),
    .mday_i (mday_i),
    .evt_o  (evt)
  );

  pint_flag u_flag (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .level_i   (level),
    .sel_chg_i (sel_chg),
    .evt_i     (evt),
    .clr_i     (flag_clr_i),
    .flag_o    (flag)
  );

  always_comb begin
    unique case (pint_sel_e'(sel_i))
      PI_OFF:  irq_no = 1'b1;
      PI_LOW:  irq_no = 1'b0;
      PI_P2HZ: irq_no = ph2_i;
      PI_P1HZ: irq_no = ph1_i;
      default: irq_no = ~flag;
    endcase
  end

  assert_level_irq_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    level && !$stable(ph2_i) && $stable(flag) && $stable(sel_i) |-> $stable(irq_no));
endmodule

// File: tb/tb_rtc_pint_gen.sv
module tb_rtc_pint_gen;
  typedef struct packed {
    logic [2:0] sel;
    logic       p2;
    logic       p1;
    logic       tk;
    logic       clr;
    logic [5:0] s;
    logic [5:0] m;
    logic [4:0] h;
    logic [4:0] d;
    logic       ex;
    logic [3:0] rq;
  } vec_t;

  localparam int NV = 31;
  localparam vec_t VECS [NV] = '{
    '{3'd0,1'b0,1'b0,1'b0,1'b0,6'd1,6'd1,5'd1,5'd2,1'b1,4'd1},  // R1
    '{3'd1,1'b1,1'b1,1'b0,1'b0,6'd1,6'd1,5'd1,5'd2,1'b0,4'd2},  // R2
    '{3'd2,1'b0,1'b1,1'b0,1'b0,6'd1,6'd1,5'd1,5'd2,1'b0,4'd3},  // R3
    '{3'd2,1'b1,1'b0,1'b0,1'b0,6'd1,6'd1,5'd1,5'd2,1'b1,4'd3},  // R3
    '{3'd3,1'b1,1'b0,1'b0,1'b0,6'd1,6'd1,5'd1,5'd2,1'b0,4'd3},  // R3
    '{3'd3,1'b0,1'b1,1'b0,1'b0,6'd1,6'd1,5'd1,5'd2,1'b1,4'd3},  // R3
    '{3'd4,1'b0,1'b0,1'b0,1'b0,6'd1,6'd1,5'd1,5'd2,1'b1,4'd10}, // R10
    '{3'd4,1'b0,1'b0,1'b1,1'b0,6'd5,6'd1,5'd1,5'd2,1'b0,4'd4},  // R4
    '{3'd4,1'b0,1'b0,1'b0,1'b0,6'd5,6'd1,5'd1,5'd2,1'b0,4'd8},  // R8
    '{3'd4,1'b0,1'b0,1'b0,1'b1,6'd5,6'd1,5'd1,5'd2,1'b1,4'd8},  // R8
    '{3'd5,1'b0,1'b0,1'b1,1'b0,6'd0,6'd1,5'd1,5'd2,1'b1,4'd10}, // R10
    '{3'd5,1'b0,1'b0,1'b1,1'b0,6'd8,6'd1,5'd1,5'd2,1'b1,4'd5},  // R5
    '{3'd5,1'b0,1'b0,1'b1,1'b0,6'd0,6'd3,5'd1,5'd2,1'b0,4'd5},  // R5
    '{3'd5,1'b0,1'b0,1'b0,1'b1,6'd0,6'd3,5'd1,5'd2,1'b1,4'd8},  // R8
    '{3'd5,1'b0,1'b0,1'b0,1'b0,6'd0,6'd3,5'd1,5'd2,1'b1,4'd5},  // R5
    '{3'd6,1'b0,1'b0,1'b0,1'b0,6'd1,6'd1,5'd1,5'd2,1'b1,4'd10}, // R10
    '{3'd6,1'b0,1'b0,1'b1,1'b0,6'd0,6'd1,5'd4,5'd2,1'b1,4'd6},  // R6
    '{3'd6,1'b0,1'b0,1'b1,1'b0,6'd0,6'd0,5'd4,5'd2,1'b0,4'd6},  // R6
    '{3'd6,1'b0,1'b0,1'b0,1'b1,6'd1,6'd0,5'd4,5'd2,1'b1,4'd8},  // R8
    '{3'd7,1'b0,1'b0,1'b0,1'b0,6'd1,6'd1,5'd1,5'd2,1'b1,4'd10}, // R10
    '{3'd7,1'b0,1'b0,1'b1,1'b0,6'd0,6'd0,5'd0,5'd2,1'b1,4'd7},  // R7
    '{3'd7,1'b0,1'b0,1'b1,1'b0,6'd0,6'd0,5'd0,5'd1,1'b0,4'd7},  // R7
    '{3'd7,1'b0,1'b0,1'b1,1'b1,6'd0,6'd0,5'd0,5'd1,1'b0,4'd9},  // R9
    '{3'd7,1'b0,1'b0,1'b0,1'b1,6'd0,6'd0,5'd0,5'd1,1'b1,4'd8},  // R8
    '{3'd4,1'b0,1'b0,1'b1,1'b0,6'd3,6'd1,5'd1,5'd2,1'b1,4'd10}, // R10
    '{3'd4,1'b0,1'b0,1'b1,1'b0,6'd4,6'd1,5'd1,5'd2,1'b0,4'd4},  // R4
    '{3'd2,1'b1,1'b0,1'b0,1'b0,6'd4,6'd1,5'd1,5'd2,1'b1,4'd3},  // R3
    '{3'd4,1'b0,1'b0,1'b0,1'b0,6'd4,6'd1,5'd1,5'd2,1'b1,4'd10}, // R10
    '{3'd4,1'b0,1'b0,1'b1,1'b0,6'd5,6'd1,5'd1,5'd2,1'b0,4'd4},  // R4
    '{3'd4,1'b0,1'b0,1'b1,1'b0,6'd6,6'd1,5'd1,5'd2,1'b0,4'd9},  // R9
    '{3'd4,1'b0,1'b0,1'b0,1'b1,6'd6,6'd1,5'd1,5'd2,1'b1,4'd8}   // R8
  };

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [2:0] sel_i = '0;
  logic       ph2_i = 1'b0, ph1_i = 1'b0, sec_tick_i = 1'b0, flag_clr_i = 1'b0;
  logic [5:0] sec_i = 6'd1, min_i = 6'd1;
  logic [4:0] hour_i = 5'd1, mday_i = 5'd2;
  logic       irq_no;
  int errors = 0, checks = 0;
  bit done = 0;

  always #10 clk_i = ~clk_i;

  rtc_pint_gen dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .sel_i(sel_i), .ph2_i(ph2_i), .ph1_i(ph1_i),
    .sec_tick_i(sec_tick_i), .sec_i(sec_i), .min_i(min_i), .hour_i(hour_i),
    .mday_i(mday_i), .flag_clr_i(flag_clr_i), .irq_no(irq_no)
  );

  task automatic check(input logic exp, input int rq, input string what);
    checks++;
    if (irq_no !== exp) begin
      errors++;
      $display("FAIL R%0d %s: irq_no=%b expected=%b", rq, what, irq_no, exp);
    end
  endtask

  initial begin
    #4000000;
    if (!done) begin
      errors++;
      $display("FAIL R0 watchdog expired: irq_no=%b expected=done", irq_no);
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    sel_i = 3'd4;
    #5;
    check(1'b1, 11, "in reset, level mode");   // R11
    #30 rst_ni = 1'b1;
    @(negedge clk_i); sel_i = 3'd0;
    @(negedge clk_i);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk_i);
      sel_i = VECS[i].sel; ph2_i = VECS[i].p2; ph1_i = VECS[i].p1;
      sec_tick_i = VECS[i].tk; flag_clr_i = VECS[i].clr;
      sec_i = VECS[i].s; min_i = VECS[i].m; hour_i = VECS[i].h; mday_i = VECS[i].d;
      @(posedge clk_i); #2;
      check(VECS[i].ex, int'(VECS[i].rq), $sformatf("vector %0d", i));
    end

    // R12: phase inputs ignored in level mode, flag clear
    @(negedge clk_i);
    sec_tick_i = 1'b0; flag_clr_i = 1'b0; sel_i = 3'd5;
    @(posedge clk_i); #2;
    ph2_i = 1'b1; ph1_i = 1'b1; #1;
    check(1'b1, 12, "phases high, flag clear");
    ph2_i = 1'b0; ph1_i = 1'b0; #1;
    check(1'b1, 12, "phases low, flag clear");

    // R12 with flag set, then R11 async reset
    @(negedge clk_i); sec_tick_i = 1'b1; sec_i = 6'd0;
    @(negedge clk_i); sec_tick_i = 1'b0;
    ph2_i = 1'b1; ph1_i = 1'b1; #1;
    check(1'b0, 12, "phases high, flag set");
    #3 rst_ni = 1'b0; #1;
    check(1'b1, 11, "async reset clears flag");
    #20 rst_ni = 1'b1;
    @(negedge clk_i);
    check(1'b1, 11, "after reset release");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule